// File: doc/BRIEF.md
# Intra-Group Rename Dependence Resolver

A group of N instructions is renamed in one cycle, and the rename table is read for all of them together. The table read therefore cannot show any mapping written by an older member of the same group. This block fixes those stale reads. Each instruction has up to two source operands and at most one destination, all named in the architectural register space. Each source is compared with the destinations of every older instruction in the group. The newest matching producer's freshly allocated physical register replaces the table value. The same priority selection runs for each destination against the older destinations. This gives the correct previous mapping to record for recovery.

The block takes one group per cycle and registers it in a single input stage. Everything after that register is combinational. For every operand the block also exports a resolved-in-group flag. The table uses it to skip a read port. The flag is raised only when the nearest older producer lies within a configurable distance `MAX_DIST`, counted in instructions (adjacent instructions have distance 1). Table storage and free-list allocation sit outside this block.

Top module: `rename_dep_resolver`

## Requirements
- R1: Every input is captured on a rising clock edge, and all outputs are computed from that captured group only. `out_valid` equals the `in_valid` captured at the previous edge, and it is 0 while `rst_n` is low.
- R2: A source with no qualifying older producer in the group outputs the table value supplied for that source, and its resolved flag is 0.
- R3: A source whose name matches the destinations of one or more older slots outputs the new physical register of the youngest of those slots, which is the one nearest in program order.
- R4: A destination whose name matches older destinations reports the new physical register of the nearest such older slot as its previous mapping. With no such match it reports its own table value.
- R5: Architectural register 0 never takes part in a match, whether as a producer or as a consumer.
- R6: A comparison counts only when the producer's destination valid bit and the consumer operand's valid bit are both 1. An invalid operand outputs its table value with its flag at 0.
- R7: A source's resolved flag is 1 exactly when a qualifying older producer exists and the distance (consumer slot − nearest producer slot) is at most `MAX_DIST`. A farther producer still bypasses the value (R3), but the flag stays 0.
- R8: A destination's resolved flag follows the same distance rule as R7, applied to its nearest older destination match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group present this cycle |
| in_dst_vld | input | N | Destination valid, bit i = slot i (slot 0 is oldest) |
| in_dst_areg | input | N*AW | Destination architectural name, slot i at [i*AW +: AW] |
| in_dst_new | input | N*PW | Newly allocated physical register per slot |
| in_dst_tbl | input | N*PW | Table value of the destination's current mapping |
| in_src_vld | input | 2N | Source valid, operand e = 2*slot + k |
| in_src_areg | input | 2N*AW | Source architectural name, operand e at [e*AW +: AW] |
| in_src_tbl | input | 2N*PW | Table value for each source operand |
| out_valid | output | 1 | Registered group valid |
| out_src_preg | output | 2N*PW | Final physical source for the scheduler |
| out_src_hit | output | 2N | Source resolved in group within MAX_DIST |
| out_dst_prev | output | N*PW | Previous mapping to record for recovery |
| out_dst_hit | output | N | Destination resolved in group within MAX_DIST |

## Verification
The bench first targets groups in which several older slots write the same register. A priority encoder with the wrong direction would forward the oldest writer's register instead of the nearest. It also covers producers three slots away with `MAX_DIST` of 2: a design that ignores the limit would raise the flag, and one that applies the limit to the data would wrongly fall back to the table. Register 0 and cleared valid bits check that phantom matches do not replace table values. A sweep over groups drawn from a four-name register pool checks every output against a model that renames the slots one by one.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int unsigned ANAME_MAX_W = 8;

  // A producer/consumer pair forms a dependence only when both are valid,
  // the names agree and the name is not the hard-wired zero register.
  function automatic logic name_hit(input logic prod_vld,
                                    input logic cons_vld,
                                    input logic [ANAME_MAX_W-1:0] prod_name,
                                    input logic [ANAME_MAX_W-1:0] cons_name);
    return prod_vld && cons_vld && (cons_name != '0) && (prod_name == cons_name);
  endfunction

  // Distance in instructions between a consumer slot and an older producer.
  function automatic logic within_reach(input int cons_slot, input int prod_slot,
                                        input int max_dist);
    return (cons_slot > prod_slot) && ((cons_slot - prod_slot) <= max_dist);
  endfunction
endpackage

// File: rtl/rdr_group_reg.sv
module rdr_group_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_d,
  input  logic [W-1:0] d,
  output logic         vld_q,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= vld_d;
      q     <= d;
    end
  end
endmodule

// File: rtl/rdr_match_sel.sv
module rdr_match_sel #(
  parameter int N    = 4,
  parameter int AW   = 5,
  parameter int PW   = 6,
  parameter int IDX  = 0,
  parameter int MAXD = 2,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            cons_vld,
  input  logic [AW-1:0]   cons_areg,
  input  logic [PW-1:0]   cons_tbl,
  input  logic [N-1:0]    prod_vld,
  input  logic [N*AW-1:0] prod_areg,
  input  logic [N*PW-1:0] prod_new,
  output logic [PW-1:0]   sel,
  output logic            any_hit,
  output logic [IW-1:0]   near_idx,
  output logic            in_reach
);
  import rdr_pkg::*;

  // Scan oldest to youngest among older slots; a later hit overrides, so
  // the surviving index is the producer nearest the consumer.
  always_comb begin
    any_hit  = 1'b0;
    near_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (j < IDX &&
          name_hit(prod_vld[j], cons_vld,
                   ANAME_MAX_W'(prod_areg[j*AW +: AW]),
                   ANAME_MAX_W'(cons_areg))) begin
        any_hit  = 1'b1;
        near_idx = IW'(j);
      end
    end
  end

  assign sel      = any_hit ? prod_new[int'(near_idx)*PW +: PW] : cons_tbl;
  assign in_reach = any_hit && within_reach(IDX, int'(near_idx), MAXD);
endmodule

// File: rtl/rename_dep_resolver.sv
module rename_dep_resolver #(
  parameter int N        = 4,
  parameter int AW       = 5,
  parameter int PW       = 6,
  parameter int MAX_DIST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [N-1:0]      in_dst_vld,
  input  logic [N*AW-1:0]   in_dst_areg,
  input  logic [N*PW-1:0]   in_dst_new,
  input  logic [N*PW-1:0]   in_dst_tbl,
  input  logic [2*N-1:0]    in_src_vld,
  input  logic [2*N*AW-1:0] in_src_areg,
  input  logic [2*N*PW-1:0] in_src_tbl,
  output logic              out_valid,
  output logic [2*N*PW-1:0] out_src_preg,
  output logic [2*N-1:0]    out_src_hit,
  output logic [N*PW-1:0]   out_dst_prev,
  output logic [N-1:0]      out_dst_hit
);
  localparam int NS    = 2 * N;
  localparam int IW    = (N > 1) ? $clog2(N) : 1;
  localparam int BUS_W = N + N*AW + 2*N*PW + NS + NS*AW + NS*PW;

  logic [BUS_W-1:0]  bus_d, bus_q;
  logic              vld_q;
  logic [N-1:0]      dv_q;
  logic [N*AW-1:0]   da_q;
  logic [N*PW-1:0]   dn_q, dt_q;
  logic [NS-1:0]     sv_q;
  logic [NS*AW-1:0]  sa_q;
  logic [NS*PW-1:0]  st_q;

  // Named internal events for the checks below
  logic [NS-1:0]     src_any;
  logic [IW-1:0]     src_near [NS];
  logic [N-1:0]      dst_any;
  logic [IW-1:0]     dst_near [N];

  assign bus_d = {in_dst_vld, in_dst_areg, in_dst_new, in_dst_tbl,
                  in_src_vld, in_src_areg, in_src_tbl};
  assign {dv_q, da_q, dn_q, dt_q, sv_q, sa_q, st_q} = bus_q;

  rdr_group_reg #(.W(BUS_W)) u_greg (
    .clk(clk), .rst_n(rst_n), .vld_d(in_valid), .d(bus_d),
    .vld_q(vld_q), .q(bus_q)
  );

  assign out_valid = vld_q;

  // R1
  grp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  for (genvar s = 0; s < NS; s++) begin : g_src
    rdr_match_sel #(.N(N), .AW(AW), .PW(PW), .IDX(s/2), .MAXD(MAX_DIST)) u_sel (
      .cons_vld (sv_q[s]),
      .cons_areg(sa_q[s*AW +: AW]),
      .cons_tbl (st_q[s*PW +: PW]),
      .prod_vld (dv_q),
      .prod_areg(da_q),
      .prod_new (dn_q),
      .sel      (out_src_preg[s*PW +: PW]),
      .any_hit  (src_any[s]),
      .near_idx (src_near[s]),
      .in_reach (out_src_hit[s])
    );

    // R2
    src_table_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_any[s] |-> (out_src_preg[s*PW +: PW] == st_q[s*PW +: PW] && !out_src_hit[s]));
    // R3
    src_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_any[s] |-> (out_src_preg[s*PW +: PW] == dn_q[int'(src_near[s])*PW +: PW]
                      && da_q[int'(src_near[s])*AW +: AW] == sa_q[s*AW +: AW]));
    // R5
    src_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sa_q[s*AW +: AW] == '0) |-> !src_any[s]);
    // R6
    src_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sv_q[s] |-> (!src_any[s] && !out_src_hit[s]));
    // R7
    src_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_src_hit[s] |-> (src_any[s] && (s/2 - int'(src_near[s])) <= MAX_DIST));
  end

  for (genvar d = 0; d < N; d++) begin : g_dst
    rdr_match_sel #(.N(N), .AW(AW), .PW(PW), .IDX(d), .MAXD(MAX_DIST)) u_sel (
      .cons_vld (dv_q[d]),
      .cons_areg(da_q[d*AW +: AW]),
      .cons_tbl (dt_q[d*PW +: PW]),
      .prod_vld (dv_q),
      .prod_areg(da_q),
      .prod_new (dn_q),
      .sel      (out_dst_prev[d*PW +: PW]),
      .any_hit  (dst_any[d]),
      .near_idx (dst_near[d]),
      .in_reach (out_dst_hit[d])
    );

    // R4
    dst_prev_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_any[d] ? (out_dst_prev[d*PW +: PW] == dn_q[int'(dst_near[d])*PW +: PW])
                 : (out_dst_prev[d*PW +: PW] == dt_q[d*PW +: PW]));
    // R8
    dst_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_dst_hit[d] |-> (dst_any[d] && (d - int'(dst_near[d])) <= MAX_DIST));
  end
endmodule

// File: tb/rename_dep_resolver_tb.sv
`timescale 1ns/1ps
module rename_dep_resolver_tb;
  localparam int N = 4, AW = 5, PW = 6, MAXD = 2, NS = 2*N;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [N-1:0] in_dst_vld = '0;
  logic [N*AW-1:0] in_dst_areg = '0;
  logic [N*PW-1:0] in_dst_new = '0, in_dst_tbl = '0;
  logic [NS-1:0] in_src_vld = '0;
  logic [NS*AW-1:0] in_src_areg = '0;
  logic [NS*PW-1:0] in_src_tbl = '0;
  logic out_valid;
  logic [NS*PW-1:0] out_src_preg;
  logic [NS-1:0] out_src_hit;
  logic [N*PW-1:0] out_dst_prev;
  logic [N-1:0] out_dst_hit;

  rename_dep_resolver #(.N(N), .AW(AW), .PW(PW), .MAX_DIST(MAXD)) u_dut (
    .clk, .rst_n, .in_valid, .in_dst_vld, .in_dst_areg, .in_dst_new, .in_dst_tbl,
    .in_src_vld, .in_src_areg, .in_src_tbl, .out_valid, .out_src_preg,
    .out_src_hit, .out_dst_prev, .out_dst_hit);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  bit dv[N]; int da[N], dn[N], dt[N];
  bit sv[NS]; int sa[NS], st[NS];
  int e_sp[NS], e_dp[N]; bit e_sh[NS], e_dh[N];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sequential reference: walk the slots in program order with a map of
  // the latest in-group writer for each architectural name.
  task automatic model();
    int owner[1<<AW];
    foreach (owner[r]) owner[r] = -1;
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 2; k++) begin
        int s = 2*i + k;
        e_sp[s] = st[s]; e_sh[s] = 0;
        if (sv[s] && sa[s] != 0 && owner[sa[s]] >= 0) begin
          e_sp[s] = dn[owner[sa[s]]];
          e_sh[s] = (i - owner[sa[s]]) <= MAXD;
        end
      end
      e_dp[i] = dt[i]; e_dh[i] = 0;
      if (dv[i] && da[i] != 0 && owner[da[i]] >= 0) begin
        e_dp[i] = dn[owner[da[i]]];
        e_dh[i] = (i - owner[da[i]]) <= MAXD;
      end
      if (dv[i] && da[i] != 0) owner[da[i]] = i;
    end
  endtask

  task automatic run_group(string name);
    model();
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < N; i++) begin
      in_dst_vld[i] = dv[i];
      in_dst_areg[i*AW +: AW] = AW'(da[i]);
      in_dst_new[i*PW +: PW] = PW'(dn[i]);
      in_dst_tbl[i*PW +: PW] = PW'(dt[i]);
    end
    for (int s = 0; s < NS; s++) begin
      in_src_vld[s] = sv[s];
      in_src_areg[s*AW +: AW] = AW'(sa[s]);
      in_src_tbl[s*PW +: PW] = PW'(st[s]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1", {name, " out_valid"}, int'(out_valid), 1);
    for (int s = 0; s < NS; s++) begin
      string tag;
      if (!sv[s]) tag = "R6";
      else if (sa[s] == 0) tag = "R5";
      else if (e_sp[s] != st[s] || e_sh[s]) tag = "R3";
      else tag = "R2";
      chk(int'(out_src_preg[s*PW +: PW]) == e_sp[s], tag, {name, " src preg"},
          int'(out_src_preg[s*PW +: PW]), e_sp[s]);
      chk(out_src_hit[s] == e_sh[s], "R7", {name, " src flag"},
          int'(out_src_hit[s]), int'(e_sh[s]));
    end
    for (int i = 0; i < N; i++) begin
      chk(int'(out_dst_prev[i*PW +: PW]) == e_dp[i], "R4", {name, " dst prev"},
          int'(out_dst_prev[i*PW +: PW]), e_dp[i]);
      chk(out_dst_hit[i] == e_dh[i], "R8", {name, " dst flag"},
          int'(out_dst_hit[i]), int'(e_dh[i]));
    end
  endtask

  task automatic clear_group();
    for (int i = 0; i < N; i++) begin
      dv[i] = 0; da[i] = 0; dn[i] = 40 + i; dt[i] = 20 + i;
    end
    for (int s = 0; s < NS; s++) begin
      sv[s] = 0; sa[s] = 0; st[s] = 1 + s;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "idle out_valid", int'(out_valid), 0);

    // R3/R4: every slot writes and reads r3; nearest writer must win
    clear_group();
    for (int i = 0; i < N; i++) begin
      dv[i] = 1; da[i] = 3; sv[2*i] = 1; sa[2*i] = 3;
    end
    run_group("chain");

    // R7: producer three slots back is bypassed but not flagged
    clear_group();
    dv[0] = 1; da[0] = 5; sv[2*(N-1)] = 1; sa[2*(N-1)] = 5;
    dv[N-1] = 1; da[N-1] = 5;
    run_group("far");

    // R5: register 0 everywhere
    clear_group();
    for (int i = 0; i < N; i++) dv[i] = 1;
    for (int s = 0; s < NS; s++) sv[s] = 1;
    run_group("zero");

    // R6: name matches but valid bits cleared on one side
    clear_group();
    da[0] = 7; sv[2] = 1; sa[2] = 7; dv[1] = 1; da[1] = 9; sa[4] = 9;
    run_group("invalid");

    // R2: distinct names, no dependence
    clear_group();
    for (int i = 0; i < N; i++) begin
      dv[i] = 1; da[i] = 10 + i; sv[2*i] = 1; sa[2*i] = 20 + i;
    end
    run_group("none");

    for (int g = 0; g < 3000; g++) begin
      for (int i = 0; i < N; i++) begin
        dv[i] = 1'($urandom_range(0, 3) != 0); da[i] = $urandom_range(0, 3);
        dn[i] = $urandom_range(0, (1<<PW)-1); dt[i] = $urandom_range(0, (1<<PW)-1);
      end
      for (int s = 0; s < NS; s++) begin
        sv[s] = 1'($urandom_range(0, 3) != 0); sa[s] = $urandom_range(0, 3);
        st[s] = $urandom_range(0, (1<<PW)-1);
      end
      run_group("sweep");
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after drain", int'(out_valid), 0);
    finish_run();
  end
endmodule